// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in an Ethernet receive path, ahead of any frame storage, and decides from the 48-bit destination address whether a frame is to be kept. The address arrives one byte per strobe, in the order the bytes appear on the wire. The first byte is marked by a start flag. One clock after the sixth byte has been taken, the block pulses a decision strobe and presents an accept flag together with a reason code.

Group (multicast) addresses are filtered through a 64-entry hash table, held in two 32-bit registers that the host loads. The table index is a 6-bit XOR fold of the address, not a CRC. The same decision also covers three other cases, each with its own enable: an exact match against a station address, acceptance of the broadcast address, and a promiscuous mode that keeps every frame. The reason code records which rule accepted the frame.

Top module: `rx_dest_filter`

## Requirements
- R1: A byte is taken when `rx_valid` is high and either `rx_first` is high (it becomes byte 0) or fewer than six bytes of the current address have been taken. Strobes without `rx_first` are ignored before the first start after reset and after the sixth byte. A new `rx_first` always restarts the address at byte 0.
- R2: `dec_valid` is high for exactly the one cycle that follows the clock edge taking byte 5. `dec_accept` and `dec_reason` keep their value until the next decision.
- R3: The table index is the low 6 bits of the XOR of per-byte terms. Bytes 0 and 3 give (b>>2)^(b<<4), bytes 1 and 4 give (b>>4)^(b<<2), and bytes 2 and 5 give (b>>6)^b. This equals the XOR of the eight 6-bit groups of the 48-bit value with byte 0 as its most significant byte.
- R4: Index 0..31 selects bit i of the low table register and index 32..63 selects bit i-32 of the high register. `tbl_wr_en[0]` loads the low register and `tbl_wr_en[1]` loads the high register from `tbl_wdata`, and the new value applies to decisions from the next cycle on. Both registers reset to zero.
- R5: An address is a group address when bit 0 of byte 0 is 1 and the address is not all ones. A group address whose table bit is 1 is accepted with reason 3. With both table registers all ones, every group address is accepted.
- R6: The all-ones address is accepted with reason 2 when `bcast_en` is high. When `bcast_en` is low it is rejected, whatever the table holds.
- R7: When `promisc_en` is high, every address is accepted with reason 1, and this rule takes precedence over all others.
- R8: When `ucast_en` is high, an address equal to `station_addr` (bits 47:40 compared with byte 0) is accepted with reason 4. This rule ranks below the group rule.
- R9: An address that no rule accepts gives `dec_accept` = 0 and reason 0. `dec_accept` is 1 exactly when the reason is non-zero.
- R10: After reset, `dec_valid`, `dec_accept` and `dec_reason` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 2 | Table register write enables (bit 0 low, bit 1 high) |
| tbl_wdata | input | 32 | Table register write data |
| station_addr | input | 48 | Station address, bits 47:40 are byte 0 |
| promisc_en | input | 1 | Accept every address |
| bcast_en | input | 1 | Accept the all-ones address |
| ucast_en | input | 1 | Accept the station address |
| rx_valid | input | 1 | Address byte strobe |
| rx_first | input | 1 | Marks byte 0 of an address |
| rx_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 group hash, 4 station |

## Verification
The hardest case to reach from the ports is a hit on one chosen table entry: a random group address lands on a given index only once in 64 tries, so most entries would never be hit. The bench loads a table with a single bit set and takes a random group address. It then rewrites the low six bits of byte 5, which form one 6-bit group on their own, so that the fold lands on that bit. Each of the 64 entries is therefore hit directly, alongside unadjusted addresses that mostly miss. The near-miss station addresses are built the same way, with one bit flipped in each byte position.

// File: rtl/rx_dest_filter_pkg.sv
// Shared types and the per-byte hash term for the receive destination filter.
// Assumes a 6-bit table index (64-entry table); the fold below depends on it.
package rx_dest_filter_pkg;

    localparam int HASH_W = 6;

    typedef enum logic [2:0] {
        RSN_REJECT  = 3'd0,
        RSN_PROMISC = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_GROUP   = 3'd3,
        RSN_STATION = 3'd4
    } reason_e;

    // Shifted contribution of one address byte; the shift pair repeats every three bytes.
    function automatic logic [HASH_W-1:0] byte_fold(input logic [7:0] b, input int unsigned pos);
        logic [HASH_W-1:0] t;
        case (pos % 3)
            0:       t = b[7:2] ^ {b[1:0], 4'b0000};
            1:       t = {2'b00, b[7:4]} ^ {b[3:0], 2'b00};
            default: t = {4'b0000, b[7:6]} ^ b[5:0];
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rdf_byte_seq.sv
// Byte sequencer: decides which strobed bytes belong to the current address
// and at which position. Assumes rx_first marks byte 0; bytes beyond the
// last position are dropped until the next rx_first.
module rdf_byte_seq #(
    parameter int ADDR_BYTES = 6,
    parameter int POS_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_first,
    output logic             take,
    output logic [POS_W-1:0] cur_pos,
    output logic             last
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);
    localparam logic [POS_W-1:0] FULL_POS = POS_W'(ADDR_BYTES);

    logic [POS_W-1:0] pos_q;

    assign cur_pos = rx_first ? '0 : pos_q;
    assign take    = rx_valid && (rx_first || (pos_q != '0 && pos_q < FULL_POS));
    assign last    = take && (cur_pos == LAST_POS);

    // Advance the position of the next expected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (take) begin
            pos_q <= cur_pos + POS_W'(1);
        end
    end
endmodule

// File: rtl/rdf_hash_acc.sv
// Hash accumulator: XOR-folds address bytes into a 6-bit table index.
// Assumes cur_pos is valid whenever take is high; hash_idx includes the
// byte currently presented so the last byte needs no extra cycle.
module rdf_hash_acc
    import rx_dest_filter_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [POS_W-1:0]  cur_pos,
    input  logic [7:0]        rx_byte,
    output logic [HASH_W-1:0] hash_idx
);
    logic [HASH_W-1:0] acc_q;
    logic [HASH_W-1:0] seed;

    assign seed     = (cur_pos == '0) ? '0 : acc_q;
    assign hash_idx = seed ^ byte_fold(rx_byte, 32'(cur_pos));

    // Hold the partial fold between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= hash_idx;
        end
    end
endmodule

// File: rtl/rdf_addr_cmp.sv
// Address classifier: tracks, byte by byte, whether the address is all ones,
// equal to the station address, and has its group bit set. Outputs include
// the current byte. Assumes station_addr[47:40] is the first wire byte.
module rdf_addr_cmp #(
    parameter int ADDR_BYTES = 6,
    parameter int POS_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [POS_W-1:0]        cur_pos,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    is_bcast,
    output logic                    is_group,
    output logic                    is_station
);
    logic       ones_q, eq_q, grp_q;
    logic       head;
    logic       ones_in, eq_in, grp_in;
    logic [7:0] st_byte;

    assign head = (cur_pos == '0);

    // Pick the station byte matching the current position.
    always_comb begin
        st_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cur_pos == POS_W'(i)) st_byte = station_addr[8*(ADDR_BYTES-1-i) +: 8];
        end
    end

    assign ones_in = (head ? 1'b1 : ones_q) && (rx_byte == 8'hFF);
    assign eq_in   = (head ? 1'b1 : eq_q) && (rx_byte == st_byte);
    assign grp_in  = head ? rx_byte[0] : grp_q;

    assign is_bcast   = ones_in;
    assign is_station = eq_in;
    assign is_group   = grp_in && !ones_in;

    // Carry the running flags across bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= 1'b0;
            eq_q   <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            ones_q <= ones_in;
            eq_q   <= eq_in;
            grp_q  <= grp_in;
        end
    end
endmodule

// File: rtl/rdf_hash_table.sv
// Hash table: host-loaded registers forming one flat bit table, plus the
// lookup of one bit by index. Assumes the table size is a multiple of REG_W.
module rdf_hash_table
    import rx_dest_filter_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int TBL_BITS = 1 << HASH_W,
    parameter int TBL_REGS = TBL_BITS / REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TBL_REGS-1:0] wr_en,
    input  logic [REG_W-1:0]    wdata,
    input  logic [HASH_W-1:0]   idx,
    output logic                hit,
    output logic [TBL_BITS-1:0] table_q
);
    for (genvar r = 0; r < TBL_REGS; r++) begin : g_reg
        logic [REG_W-1:0] reg_q;

        // Load one table register from the host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (wr_en[r]) begin
                reg_q <= wdata;
            end
        end

        assign table_q[r*REG_W +: REG_W] = reg_q;
    end

    assign hit = table_q[idx];
endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter (top). Takes the destination address
// byte-serially and, one cycle after the last byte, reports accept and the
// rule that accepted it. Assumes a single address in flight at a time.
module rx_dest_filter
    import rx_dest_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int REG_W      = 32,
    parameter int TBL_BITS   = 1 << HASH_W,
    parameter int TBL_REGS   = TBL_BITS / REG_W,
    parameter int POS_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TBL_REGS-1:0]     tbl_wr_en,
    input  logic [REG_W-1:0]        tbl_wdata,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    promisc_en,
    input  logic                    bcast_en,
    input  logic                    ucast_en,
    input  logic                    rx_valid,
    input  logic                    rx_first,
    input  logic [7:0]              rx_byte,
    output logic                    dec_valid,
    output logic                    dec_accept,
    output logic [2:0]              dec_reason
);
    logic              seq_take, seq_last;
    logic [POS_W-1:0]  seq_pos;
    logic [HASH_W-1:0] hash_idx;
    logic              is_bcast, is_group, is_station;
    logic              tbl_hit;
    logic [TBL_BITS-1:0] table_q;
    logic              accept_c;
    reason_e           reason_c;
    logic              valid_q, accept_q;
    reason_e           reason_q;

    rdf_byte_seq #(.ADDR_BYTES(ADDR_BYTES), .POS_W(POS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .take(seq_take), .cur_pos(seq_pos), .last(seq_last)
    );

    rdf_hash_acc #(.POS_W(POS_W)) u_hash (
        .clk(clk), .rst_n(rst_n), .take(seq_take), .cur_pos(seq_pos),
        .rx_byte(rx_byte), .hash_idx(hash_idx)
    );

    rdf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES), .POS_W(POS_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .take(seq_take), .cur_pos(seq_pos),
        .rx_byte(rx_byte), .station_addr(station_addr),
        .is_bcast(is_bcast), .is_group(is_group), .is_station(is_station)
    );

    rdf_hash_table #(.REG_W(REG_W), .TBL_BITS(TBL_BITS), .TBL_REGS(TBL_REGS)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wdata(tbl_wdata),
        .idx(hash_idx), .hit(tbl_hit), .table_q(table_q)
    );

    // Any enabled rule keeps the frame.
    assign accept_c = promisc_en || (is_bcast && bcast_en) ||
                      (is_group && tbl_hit) || (is_station && ucast_en);

    // Fixed-priority choice of the reporting rule.
    always_comb begin
        if (promisc_en)                reason_c = RSN_PROMISC;
        else if (is_bcast && bcast_en) reason_c = RSN_BCAST;
        else if (is_group && tbl_hit)  reason_c = RSN_GROUP;
        else if (is_station && ucast_en) reason_c = RSN_STATION;
        else                           reason_c = RSN_REJECT;
    end

    // Register the decision on the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
            reason_q <= RSN_REJECT;
        end else begin
            valid_q <= seq_last;
            if (seq_last) begin
                accept_q <= accept_c;
                reason_q <= reason_c;
            end
        end
    end

    assign dec_valid  = valid_q;
    assign dec_accept = accept_q;
    assign dec_reason = reason_q;
endmodule

// File: rtl/rx_dest_filter_chk.sv
// Property checker for the receive destination filter, bound to the top.
// Assumes it sees the sequencer's last-byte flag and the flat table.
module rx_dest_filter_chk #(
    parameter int REG_W    = 32,
    parameter int TBL_BITS = 64,
    parameter int TBL_REGS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                seq_last,
    input logic                promisc_en,
    input logic [TBL_REGS-1:0] tbl_wr_en,
    input logic [REG_W-1:0]    tbl_wdata,
    input logic [TBL_BITS-1:0] table_q,
    input logic                dec_valid,
    input logic                dec_accept,
    input logic [2:0]          dec_reason
);
    AST_DEC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        seq_last |=> dec_valid); // R2

    AST_NO_STRAY_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_last |=> !dec_valid); // R2

    AST_PROMISC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_last && promisc_en) |=> (dec_accept && dec_reason == 3'd1)); // R7

    AST_REASON_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_reason != 3'd0))); // R9

    for (genvar r = 0; r < TBL_REGS; r++) begin : g_wr
        AST_TBL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_wr_en[r] |=> (table_q[r*REG_W +: REG_W] == $past(tbl_wdata))); // R4
    end
endmodule

bind rx_dest_filter rx_dest_filter_chk #(
    .REG_W(REG_W), .TBL_BITS(TBL_BITS), .TBL_REGS(TBL_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seq_last(seq_last), .promisc_en(promisc_en),
    .tbl_wr_en(tbl_wr_en), .tbl_wdata(tbl_wdata), .table_q(table_q),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tbl_wr_en = '0;
    logic [31:0] tbl_wdata = '0;
    logic [47:0] station_addr = '0;
    logic        promisc_en = 1'b0;
    logic        bcast_en = 1'b0;
    logic        ucast_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] tbl_model = '0;
    logic [31:0] seed = 32'h1234_5678;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rx_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wdata(tbl_wdata),
        .station_addr(station_addr), .promisc_en(promisc_en), .bcast_en(bcast_en),
        .ucast_en(ucast_en), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_reason(dec_reason)
    );

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int g = 0; g < 8; g++) h ^= a[6*g +: 6];
        return h;
    endfunction

    // Expected {accept, reason} from the requirement rules and priority.
    function automatic logic [3:0] ref_dec(input logic [47:0] a);
        logic bc  = (a == 48'hFFFF_FFFF_FFFF);
        logic grp = a[40] && !bc;
        if (promisc_en)                         return {1'b1, 3'd1};
        if (bc && bcast_en)                     return {1'b1, 3'd2};
        if (grp && tbl_model[ref_hash(a)])      return {1'b1, 3'd3};
        if (ucast_en && a == station_addr)      return {1'b1, 3'd4};
        return 4'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rnd_addr(output logic [47:0] a);
        seed = seed * 32'd1664525 + 32'd1013904223;
        a[47:32] = seed[31:16];
        seed = seed * 32'd1664525 + 32'd1013904223;
        a[31:0] = seed;
    endtask

    task automatic tbl_write(input int r, input logic [31:0] v);
        @(negedge clk);
        tbl_wr_en = 2'(1 << r);
        tbl_wdata = v;
        @(negedge clk);
        tbl_wr_en = '0;
        tbl_model[r*32 +: 32] = v;
    endtask

    // Drive six bytes, optionally with an idle cycle between them, and check the decision.
    task automatic run_frame(input logic [47:0] a, input bit gap, input string tag);
        logic [3:0] e;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_first = (i == 0);
            rx_byte  = a[8*(5-i) +: 8];
            if (gap && i < 5) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_first = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_first = 1'b0;
        e = ref_dec(a);
        chk({tag, " R2 valid"}, 32'(dec_valid), 32'd1);
        chk({tag, " decision"}, {28'd0, dec_accept, dec_reason}, {28'd0, e});
        @(negedge clk);
        chk({tag, " R2 pulse"}, 32'(dec_valid), 32'd0);
    endtask

    initial begin
        logic [47:0] a;
        logic [3:0]  held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid", 32'(dec_valid), 0);
        chk("R10 accept", 32'(dec_accept), 0);
        chk("R10 reason", 32'(dec_reason), 0);

        // R1: strobes before any start are ignored.
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1'b1; rx_byte = 8'(i); @(negedge clk);
            chk("R1 stray before start", 32'(dec_valid), 0);
        end
        rx_valid = 1'b0;

        // R4: reset table is empty, so a group address is rejected.
        run_frame(48'h0100_5E00_0001, 1'b0, "R4 reset table");

        // R1: bytes after the sixth are ignored and the decision holds.
        bcast_en = 1'b1;
        run_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R6 bcast");
        held = {dec_accept, dec_reason};
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1'b1; rx_byte = 8'hA5; @(negedge clk);
            chk("R1 extra bytes", 32'(dec_valid), 0);
            chk("R2 hold", 32'({dec_accept, dec_reason}), 32'(held));
        end
        rx_valid = 1'b0;

        // R1: a new start in mid-address restarts at byte 0.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_first = (i == 0); rx_byte = 8'h33;
        end
        run_frame(48'h0300_0000_0007, 1'b1, "R1 restart");
        bcast_en = 1'b0;

        // R3 R4 R5: sweep every table bit with steered and random group addresses.
        for (int k = 0; k < 64; k++) begin
            tbl_write(0, (k < 32) ? (32'd1 << k) : 32'd0);
            tbl_write(1, (k >= 32) ? (32'd1 << (k - 32)) : 32'd0);
            for (int j = 0; j < 4; j++) begin
                rnd_addr(a);
                a[40] = 1'b1;
                a[5:0] = a[5:0] ^ ref_hash(a) ^ 6'(k);
                chk("R3 steer", 32'(ref_hash(a)), 32'(k));
                run_frame(a, j[0], "R5 hit");
                rnd_addr(a);
                a[40] = 1'b1;
                run_frame(a, j[1], "R3 random");
            end
        end

        // R5: all-ones table accepts every group address.
        tbl_write(0, 32'hFFFF_FFFF);
        tbl_write(1, 32'hFFFF_FFFF);
        for (int j = 0; j < 32; j++) begin
            rnd_addr(a); a[40] = 1'b1;
            if (a == 48'hFFFF_FFFF_FFFF) a[0] = 1'b0;
            run_frame(a, 1'b0, "R5 all ones");
        end
        // R6: broadcast disabled is rejected even with a full table.
        run_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R6 bcast off");
        // R9: individual address, no rule enabled.
        run_frame(48'h0211_2233_4455, 1'b0, "R9 reject");

        // R7: promiscuous overrides everything.
        promisc_en = 1'b1; bcast_en = 1'b1;
        run_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R7 over bcast");
        for (int j = 0; j < 8; j++) begin
            rnd_addr(a); run_frame(a, 1'b0, "R7 promisc");
        end
        promisc_en = 1'b0; bcast_en = 1'b0;

        // R8: station match, enable off, and one-bit misses per byte.
        tbl_write(0, 32'd0);
        tbl_write(1, 32'd0);
        station_addr = 48'h0A1B_2C3D_4E5F;
        ucast_en = 1'b1;
        run_frame(station_addr, 1'b1, "R8 station");
        for (int i = 0; i < 6; i++) begin
            run_frame(station_addr ^ (48'h1 << (8*i + 3)), 1'b0, "R8 near miss");
        end
        ucast_en = 1'b0;
        run_frame(station_addr, 1'b0, "R8 disabled");

        // R8 R5: a group station address ranks below a table hit.
        ucast_en = 1'b1;
        station_addr = 48'h0B00_0000_0001;
        run_frame(station_addr, 1'b0, "R8 group station miss");
        tbl_write(0, 32'hFFFF_FFFF);
        tbl_write(1, 32'hFFFF_FFFF);
        run_frame(station_addr, 1'b0, "R5 group over station");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule